// File: doc/BRIEF.md
# SPI FIFO Interrupt and Status Unit

This unit is the register-facing half of an SPI master. It owns two byte-wide queues of 32 entries: a transmit queue that the host fills through a word-addressed register port, and a receive queue that the host drains through the same port. The serial engine on the other side pops transmit bytes and pushes received bytes. The unit does not shift bits, make a serial clock or decode chip selects.

A host write can load one to four bytes from a 32-bit word in one cycle. A host read can unload up to a full word. A configuration bit picks whether the low or the high byte goes first. Four status bits follow queue occupancy: two are plain full flags and two compare against host-programmable thresholds. Three more are sticky: a serial-side pop from an empty transmit queue, a receive byte dropped because the queue was full, and an external mode-fault pulse. The interrupt mask has separate set and clear addresses and can be read but not written directly. A registered interrupt line goes high whenever any enabled status bit is set. While the linear-read input is high, the status register is frozen except for host clears.

Top module: `spi_fifo_irq`

## Requirements
- R1: Word addresses are 0 config (bit 26 byte order, other bits read 0), 1 status, 2 mask set, 3 mask clear, 4 mask (read-only), 5 transmit word, 6 receive word, 7 transmit threshold, 8 receive threshold, 9/10/11 transmit 1/2/3 bytes. Addresses 2, 3, 5, 9, 10 and 11 read as 0. Read data is registered and appears the cycle after the read strobe. Reset leaves status 0x04, mask 0, both thresholds 1 and irq low.
- R2: A write to address 5 pushes WORD_BYTES bytes (default 4). Writes to 9, 10 and 11 push 1, 2 and 3 bytes. With config bit 26 clear, the bytes come from data bits [7:0] upward. With it set, they come from bits [31:24] downward. The serial side sees bytes in push order on tx_byte.
- R3: A push stops at the first byte that does not fit in the 32-entry transmit queue, and the extra bytes are lost. Status bit 3 is set while the queue holds 32 bytes.
- R4: A read of address 6 pops up to WORD_BYTES bytes. With bit 26 clear, the first byte goes to bits [7:0] and the next ones go upward. With it set, the first byte goes to bits [31:24] and the next ones go downward. Byte positions with no data read as 0.
- R5: A receive byte that arrives when the receive queue holds 32 bytes is dropped and sets sticky bit 0. Status bit 5 is set while the receive queue is full.
- R6: Status bit 4 is set when the receive count is at least the receive threshold. Status bit 2 is set when the transmit count is below the transmit threshold.
- R7: A serial-side pop from an empty transmit queue sets sticky bit 6.
- R8: A status read returns bits [6:0] and then clears all of them. Writing 1s to the status address clears those bits. The occupancy bits (5..2) are recomputed on every register write and every queue event, so after such a clear they show the queue state again.
- R9: Writing to the mask-set address ORs the data into the mask. Writing to the mask-clear address removes those bits from the mask. A write to the mask address itself has no effect.
- R10: irq is a register equal to the OR over (mask AND status).
- R11: While linear_mode is high, no status bit is set or recomputed. The queues still move, and host clears still apply.
- R12: A one-cycle mode_fail pulse sets sticky status bit 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| reg_addr | input | 4 | Register word address |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Registered read data |
| linear_mode | input | 1 | Freezes status updates while high |
| mode_fail | input | 1 | Mode-fault event pulse |
| tx_pop | input | 1 | Serial side takes one transmit byte |
| tx_byte | output | 8 | Head of the transmit queue |
| rx_push | input | 1 | Serial side delivers one receive byte |
| rx_byte | input | 8 | Received byte |
| irq | output | 1 | Interrupt request |

## Verification
The assertions assume that at most one of reg_wr and reg_rd is high in a cycle and that each strobe addresses one register. The read-clear property also assumes that no queue event or mode fault arrives in the same cycle as the status read. The bench drives every input on the falling edge and raises only one strobe or one serial-side event at a time. Because of this, every sticky or read-clear check sees a single cause. It reaches the overflow and empty-pop cases by pushing past 32 entries or popping an empty queue on purpose.

// File: rtl/spi_fifo_irq.sv
module spi_fifo_irq #(
  parameter int DEPTH      = 32,
  parameter int WORD_BYTES = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [3:0]  reg_addr,
  input  logic        reg_wr,
  input  logic        reg_rd,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  input  logic        linear_mode,
  input  logic        mode_fail,
  input  logic        tx_pop,
  output logic [7:0]  tx_byte,
  input  logic        rx_push,
  input  logic [7:0]  rx_byte,
  output logic        irq
);

  localparam int PW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [CW-1:0] FULL = CW'(DEPTH);
  localparam logic [2:0] NB = 3'(WORD_BYTES);

  localparam logic [3:0] A_CFG = 4'd0, A_STAT = 4'd1, A_IEN = 4'd2, A_IDIS = 4'd3,
                         A_MASK = 4'd4, A_TXD = 4'd5, A_RXD = 4'd6, A_TXTHR = 4'd7,
                         A_RXTHR = 4'd8, A_TX1 = 4'd9, A_TX2 = 4'd10, A_TX3 = 4'd11;

  logic [7:0]    tx_mem [DEPTH];
  logic [7:0]    rx_mem [DEPTH];
  logic [PW-1:0] tx_wp, tx_rp, rx_wp, rx_rp;
  logic [CW-1:0] tx_cnt_q, rx_cnt_q, tx_cnt_d, rx_cnt_d;
  logic [CW-1:0] txthr_q, rxthr_q, txthr_d, rxthr_d;
  logic          big_end;
  logic [6:0]    st_q, st_d, mask_q, mask_d;

  wire wr_cfg   = reg_wr && reg_addr == A_CFG;
  wire wr_st    = reg_wr && reg_addr == A_STAT;
  wire wr_ien   = reg_wr && reg_addr == A_IEN;
  wire wr_idis  = reg_wr && reg_addr == A_IDIS;
  wire wr_txthr = reg_wr && reg_addr == A_TXTHR;
  wire wr_rxthr = reg_wr && reg_addr == A_RXTHR;
  wire rd_st    = reg_rd && reg_addr == A_STAT;
  wire rd_rx    = reg_rd && reg_addr == A_RXD;

  logic [2:0] tx_nreq, tx_npush, rx_npop;
  always_comb begin
    tx_nreq = 3'd0;
    if (reg_wr) begin
      case (reg_addr)
        A_TXD:   tx_nreq = NB;
        A_TX1:   tx_nreq = 3'd1;
        A_TX2:   tx_nreq = 3'd2;
        A_TX3:   tx_nreq = 3'd3;
        default: tx_nreq = 3'd0;
      endcase
    end
  end

  wire [CW-1:0] tx_space = FULL - tx_cnt_q;
  assign tx_npush = (CW'(tx_nreq) > tx_space) ? tx_space[2:0] : tx_nreq;
  assign rx_npop  = !rd_rx ? 3'd0 : (CW'(NB) > rx_cnt_q) ? rx_cnt_q[2:0] : NB;

  wire tx_pop_ok  = tx_pop && tx_cnt_q != '0;
  wire uf_evt     = tx_pop && tx_cnt_q == '0;
  wire rx_push_ok = rx_push && rx_cnt_q != FULL;
  wire of_evt     = rx_push && rx_cnt_q == FULL;

  assign tx_cnt_d = tx_cnt_q + CW'(tx_npush) - CW'(tx_pop_ok);
  assign rx_cnt_d = rx_cnt_q + CW'(rx_push_ok) - CW'(rx_npop);
  assign txthr_d  = wr_txthr ? reg_wdata[CW-1:0] : txthr_q;
  assign rxthr_d  = wr_rxthr ? reg_wdata[CW-1:0] : rxthr_q;
  assign tx_byte  = tx_mem[tx_rp];

  wire upd = !linear_mode && (reg_wr || tx_pop || rx_push || rd_rx || mode_fail);
  wire [3:0] live = {rx_cnt_d == FULL, rx_cnt_d >= rxthr_d,
                     tx_cnt_d == FULL, tx_cnt_d < txthr_d};

  always_comb begin
    st_d = st_q;
    if (rd_st) st_d = '0;
    if (wr_st) st_d = st_d & ~reg_wdata[6:0];
    if (upd) begin
      st_d[5:2] = live;
      st_d[6]   = st_d[6] | uf_evt;
      st_d[1]   = st_d[1] | mode_fail;
      st_d[0]   = st_d[0] | of_evt;
    end
  end

  always_comb begin
    mask_d = mask_q;
    if (wr_ien)  mask_d = mask_d | reg_wdata[6:0];
    if (wr_idis) mask_d = mask_d & ~reg_wdata[6:0];
  end

  logic [31:0] rx_word;
  always_comb begin
    rx_word = '0;
    for (int k = 0; k < 4; k++)
      if (3'(k) < rx_npop)
        rx_word[8*(big_end ? 3 - k : k) +: 8] = rx_mem[rx_rp + PW'(k)];
  end

  logic [31:0] rd_mux;
  always_comb begin
    case (reg_addr)
      A_CFG:   rd_mux = {5'd0, big_end, 26'd0};
      A_STAT:  rd_mux = {25'd0, st_q};
      A_MASK:  rd_mux = {25'd0, mask_q};
      A_RXD:   rd_mux = rx_word;
      A_TXTHR: rd_mux = 32'(txthr_q);
      A_RXTHR: rd_mux = 32'(rxthr_q);
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    for (int k = 0; k < 4; k++)
      if (3'(k) < tx_npush)
        tx_mem[tx_wp + PW'(k)] <= big_end ? reg_wdata[8*(3-k) +: 8] : reg_wdata[8*k +: 8];
    if (rx_push_ok) rx_mem[rx_wp] <= rx_byte;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_wp <= '0; tx_rp <= '0; rx_wp <= '0; rx_rp <= '0;
      tx_cnt_q <= '0; rx_cnt_q <= '0;
      txthr_q <= CW'(1); rxthr_q <= CW'(1);
      big_end <= 1'b0;
      st_q <= 7'h04;
      mask_q <= '0;
      irq <= 1'b0;
      reg_rdata <= '0;
    end else begin
      tx_wp <= tx_wp + PW'(tx_npush);
      tx_rp <= tx_rp + PW'(tx_pop_ok);
      rx_wp <= rx_wp + PW'(rx_push_ok);
      rx_rp <= rx_rp + PW'(rx_npop);
      tx_cnt_q <= tx_cnt_d;
      rx_cnt_q <= rx_cnt_d;
      txthr_q <= txthr_d;
      rxthr_q <= rxthr_d;
      if (wr_cfg) big_end <= reg_wdata[26];
      st_q <= st_d;
      mask_q <= mask_d;
      irq <= |(mask_d & st_d);
      if (reg_rd) reg_rdata <= rd_mux;
    end
  end

endmodule

// File: rtl/spi_fifo_irq_chk.sv
module spi_fifo_irq_chk #(
  parameter int DEPTH = 32,
  parameter int CW    = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic [3:0]    reg_addr,
  input logic          reg_wr,
  input logic          reg_rd,
  input logic          linear_mode,
  input logic          mode_fail,
  input logic          tx_pop,
  input logic          rx_push,
  input logic [CW-1:0] tx_cnt,
  input logic [CW-1:0] rx_cnt,
  input logic [6:0]    st,
  input logic [6:0]    mask,
  input logic          irq
);

  a_r3_tx_bound: assert property (@(posedge clk) disable iff (!rst_n)
    tx_cnt <= CW'(DEPTH));

  a_r5_overflow_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_push && rx_cnt == CW'(DEPTH) && !linear_mode) |=> st[0]);

  a_r7_underflow_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_pop && tx_cnt == '0 && !linear_mode) |=> st[6]);

  a_r8_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && !reg_wr && reg_addr == 4'd1 && !tx_pop && !rx_push && !mode_fail)
      |=> st == '0);

  a_r9_mask_readonly: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == 4'd4) |=> $stable(mask));

  a_r10_irq_level: assert property (@(posedge clk) disable iff (!rst_n)
    irq == |(mask & st));

  a_r11_linear_freeze: assert property (@(posedge clk) disable iff (!rst_n)
    (linear_mode && !reg_wr && !reg_rd) |=> $stable(st));

endmodule

bind spi_fifo_irq spi_fifo_irq_chk #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_rd(reg_rd),
  .linear_mode(linear_mode), .mode_fail(mode_fail), .tx_pop(tx_pop), .rx_push(rx_push),
  .tx_cnt(tx_cnt_q), .rx_cnt(rx_cnt_q), .st(st_q), .mask(mask_q), .irq(irq)
);

// File: tb/test_spi_fifo_irq.sv
module test_spi_fifo_irq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        linear_mode = 1'b0, mode_fail = 1'b0;
  logic        tx_pop = 1'b0, rx_push = 1'b0;
  logic [7:0]  tx_byte, rx_byte = '0;
  logic        irq;
  int checks = 0, errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  spi_fifo_irq i_spi_fifo_irq (.*);

  localparam logic [3:0] CFG = 0, STAT = 1, IEN = 2, IDIS = 3, MASK = 4, TXD = 5,
                         RXD = 6, TXTHR = 7, RXTHR = 8, TX1 = 9, TX2 = 10, TX3 = 11;

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(logic [3:0] a, logic [31:0] d);
    @(negedge clk); reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd(logic [3:0] a, output logic [31:0] d);
    @(negedge clk); reg_addr = a; reg_rd = 1'b1;
    @(negedge clk); reg_rd = 1'b0; d = reg_rdata;
  endtask

  task automatic rd_chk(string req, logic [3:0] a, logic [31:0] exp);
    logic [31:0] d;
    rd(a, d);
    check(req, d, exp);
  endtask

  task automatic pop_chk(string req, logic [7:0] exp);
    @(negedge clk);
    check(req, 32'(tx_byte), 32'(exp));
    tx_pop = 1'b1;
    @(negedge clk); tx_pop = 1'b0;
  endtask

  task automatic pop_empty();
    @(negedge clk); tx_pop = 1'b1;
    @(negedge clk); tx_pop = 1'b0;
  endtask

  task automatic push_rx(logic [7:0] b);
    @(negedge clk); rx_byte = b; rx_push = 1'b1;
    @(negedge clk); rx_push = 1'b0;
  endtask

  task automatic t_reset();
    check("R1 irq after reset", 32'(irq), 0);
    rd_chk("R1 status reset", STAT, 32'h04);
    rd_chk("R1 mask reset", MASK, 0);
    rd_chk("R1 tx threshold reset", TXTHR, 1);
    rd_chk("R1 rx threshold reset", RXTHR, 1);
    rd_chk("R1 write-only address reads 0", IEN, 0);
  endtask

  task automatic t_tx_le();
    wr(CFG, 0);
    wr(TXD, 32'h44332211);
    pop_chk("R2 le byte0", 8'h11); pop_chk("R2 le byte1", 8'h22);
    pop_chk("R2 le byte2", 8'h33); pop_chk("R2 le byte3", 8'h44);
    wr(TX2, 32'h0000CDAB);
    pop_chk("R2 le two-byte first", 8'hAB); pop_chk("R2 le two-byte second", 8'hCD);
  endtask

  task automatic t_tx_be();
    wr(CFG, 32'h0400_0000);
    rd_chk("R1 config readback", CFG, 32'h0400_0000);
    wr(TX1, 32'hAABBCCDD);
    pop_chk("R2 be single", 8'hAA);
    wr(TX3, 32'hAABBCCDD);
    pop_chk("R2 be three a", 8'hAA); pop_chk("R2 be three b", 8'hBB);
    pop_chk("R2 be three c", 8'hCC);
    wr(TXD, 32'hAABBCCDD);
    pop_chk("R2 be word a", 8'hAA); pop_chk("R2 be word b", 8'hBB);
    pop_chk("R2 be word c", 8'hCC); pop_chk("R2 be word d", 8'hDD);
    wr(CFG, 0);
  endtask

  task automatic t_underflow();
    logic [31:0] d;
    rd(STAT, d);
    pop_empty();
    rd_chk("R7 underflow sticky", STAT, 32'h44);
    rd_chk("R8 read clears status", STAT, 32'h00);
    pop_empty();
    wr(STAT, 32'h40);
    rd_chk("R8 write-one clears sticky", STAT, 32'h04);
    wr(STAT, 32'h04);
    rd_chk("R8 live bit recomputed after clear", STAT, 32'h04);
  endtask

  task automatic t_rx_pack();
    for (int i = 1; i <= 5; i++) push_rx(8'(i));
    rd_chk("R4 le word", RXD, 32'h04030201);
    rd_chk("R4 partial zero-filled", RXD, 32'h00000005);
    rd_chk("R4 empty reads zero", RXD, 32'h0);
    wr(CFG, 32'h0400_0000);
    push_rx(8'hA1); push_rx(8'hB2);
    rd_chk("R4 be partial", RXD, 32'hA1B20000);
    wr(CFG, 0);
  endtask

  task automatic t_overflow();
    logic [31:0] d;
    rd(STAT, d);
    for (int i = 0; i < 33; i++) push_rx(8'(i));
    rd_chk("R5 overflow with full and not-empty", STAT, 32'h35);
    for (int j = 0; j < 8; j++)
      rd_chk("R5 stored bytes intact", RXD,
             {8'(4*j+3), 8'(4*j+2), 8'(4*j+1), 8'(4*j)});
    rd_chk("R5 dropped byte absent", RXD, 32'h0);
  endtask

  task automatic t_thresholds();
    logic [31:0] d;
    wr(RXTHR, 3);
    rd(STAT, d);
    push_rx(8'h10); push_rx(8'h11);
    rd_chk("R6 rx below threshold", STAT, 32'h04);
    push_rx(8'h12);
    rd_chk("R6 rx at threshold", STAT, 32'h14);
    wr(TXTHR, 2);
    wr(TX1, 32'h5A); wr(TX1, 32'h5B);
    rd_chk("R6 tx at threshold not below", STAT, 32'h10);
    pop_chk("R6 tx drain a", 8'h5A); pop_chk("R6 tx drain b", 8'h5B);
    rd_chk("R6 rx drain", RXD, 32'h00121110);
    wr(TXTHR, 1); wr(RXTHR, 1);
  endtask

  task automatic t_tx_full();
    logic [31:0] d;
    for (int k = 0; k < 8; k++)
      wr(TXD, {8'(4*k+3), 8'(4*k+2), 8'(4*k+1), 8'(4*k)});
    wr(TXD, 32'hEEEEEEEE);
    rd(STAT, d);
    check("R3 tx full flag", d, 32'h08);
    for (int n = 0; n < 32; n++) pop_chk("R3 extra bytes dropped", 8'(n));
    pop_empty();
    rd_chk("R3 queue was exactly full", STAT, 32'h44);
  endtask

  task automatic t_irq();
    logic [31:0] d;
    pop_empty();
    @(negedge clk); check("R10 masked off", 32'(irq), 0);
    wr(IEN, 32'h40);
    check("R10 irq on enable", 32'(irq), 1);
    rd_chk("R9 set adds bit", MASK, 32'h40);
    wr(MASK, 32'h7F);
    rd_chk("R9 mask write ignored", MASK, 32'h40);
    wr(IDIS, 32'h40);
    check("R10 irq off on disable", 32'(irq), 0);
    rd_chk("R9 clear removes bit", MASK, 32'h00);
    wr(IEN, 32'h04);
    check("R10 irq from live bit", 32'(irq), 1);
    wr(IEN, 32'h40);
    rd(STAT, d);
    check("R10 irq drops after status read", 32'(irq), 0);
    wr(IDIS, 32'h7F);
  endtask

  task automatic t_linear();
    logic [31:0] d;
    rd(STAT, d);
    linear_mode = 1'b1;
    pop_empty();
    push_rx(8'h55);
    @(negedge clk); mode_fail = 1'b1;
    @(negedge clk); mode_fail = 1'b0;
    rd_chk("R11 status frozen", STAT, 32'h00);
    linear_mode = 1'b0;
    rd_chk("R11 queue still moved", RXD, 32'h55);
    rd_chk("R11 updates resume", STAT, 32'h04);
  endtask

  task automatic t_mode_fail();
    logic [31:0] d;
    rd(STAT, d);
    @(negedge clk); mode_fail = 1'b1;
    @(negedge clk); mode_fail = 1'b0;
    rd_chk("R12 mode fail sticky", STAT, 32'h06);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_tx_le();
    t_tx_be();
    t_underflow();
    t_rx_pack();
    t_overflow();
    t_thresholds();
    t_tx_full();
    t_irq();
    t_linear();
    t_mode_fail();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule